// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

This block holds 32 hardware semaphores that two processor cores use to guard shared resources. Each semaphore is free or held; a held semaphore records the owning core and an 8-bit process number. A core takes a semaphore either by writing a lock request to the semaphore's main register and reading it back to confirm ownership (two-step lock), or by reading the semaphore's lock-read register, which takes a free semaphore and reports the result in the same access (one-step lock). Only the recorded owner can release a semaphore. A keyed bulk-release write frees every semaphore owned by one core, for example after that core has been restarted.

Each core has its own interrupt enable, status and clear registers, with one bit per semaphore. A core that waits for a semaphore enables that bit and is interrupted when the semaphore is released. The block has two register ports, one per core. Each port carries valid, write, word address, write data and a core-number sideband, and ownership is always taken from that sideband. Read data appears on the cycle after the request.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset every semaphore is free and reads as 0. The key register, all enable bits and all status bits are 0, and both interrupt outputs are low.
- R2: A write to main register x (address 0x00+x) with bit 31 set takes semaphore x if it is free. It records the port's core sideband and write-data bits [7:0] as the process number, and the core field of the write data is ignored. A read of a held semaphore returns bit 31 = 1, the owner core in bit 8 and the process number in bits [7:0].
- R3: A read of lock-read register x (address 0x20+x) takes semaphore x when it is free, records the reader's core with process number 0, and returns 0x80000000 with the core in bit 8.
- R4: A lock write or lock read aimed at a semaphore that is already held leaves its state unchanged, and the returned data shows the current owner.
- R5: A write to main register x with bit 31 clear releases semaphore x only when the port's core and write-data bits [7:0] both equal the stored owner. A mismatched release is ignored. A released semaphore reads as 0.
- R6: The key register (address 0x41, bits [15:0]) is readable and writable. A write to address 0x40 with the key in bits [31:16] and a core number in bit 8 frees every semaphore held by that core, but only when the written key equals the key register. Otherwise nothing changes.
- R7: For core c, the enable register sits at 0x50+4c, the status register at 0x51+4c and the clear register at 0x52+4c, with bit x standing for semaphore x. A release of semaphore x sets status bit x of every core whose enable bit x is set. Interrupt output c is high whenever core c has a status bit and its enable bit both set.
- R8: A write to a clear register clears the status bits where the data has a 1. A release in the same cycle still sets its status bit.
- R9: A plain read of a main register changes no state.
- R10: When both ports access the same semaphore (main or lock-read register) or the same address in one cycle, port 0's access takes effect and port 1's access has no effect on state.
- R11: Read data appears on the port's read-data output one cycle after the request and reflects the state after that cycle's update. Reads of the clear, bulk-release or unmapped addresses return 0. Writes to lock-read or status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 2 | Access request, one bit per port |
| busWrite | input | 2 | 1 = write, 0 = read, per port |
| busCore | input | 2x1 | Core-number sideband per port |
| busAddr | input | 2x8 | Word address per port |
| busWdata | input | 2x32 | Write data per port |
| busRdata | output | 2x32 | Read data per port, valid one cycle after a read |
| irqOut | output | 2 | Release interrupt per core |

## Verification
The hardest situations to reach are same-cycle collisions. Examples are both cores racing for one free semaphore, and a release landing in the same cycle as a write that clears the status bit it sets. These need both ports driven with related addresses in the same cycle. Random stimulus therefore confines its accesses to four semaphores and a handful of control addresses, with few process numbers and two key values, so that collisions, owner matches and valid bulk keys come up often. Directed sequences then force the exact racing lock reads and the release-versus-clear overlap.

// File: rtl/sem_pkg.sv
package sem_pkg;
  parameter int NUM_SEM   = 32;
  parameter int IDX_W     = $clog2(NUM_SEM);
  parameter int NUM_CORES = 2;
  parameter int NUM_PORTS = 2;
  parameter int CORE_W    = $clog2(NUM_CORES);
  parameter int PROC_W    = 8;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 8;
  parameter int KEY_W     = 16;
  parameter int LOCK_BIT  = DATA_W - 1;
  parameter int CORE_LSB  = 8;
  parameter logic [ADDR_W-1:0] LR_BASE  = 8'h20;
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h40;
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h41;
  parameter logic [ADDR_W-1:0] IRQ_BASE = 8'h50;

  typedef enum logic [2:0] {RD_NONE, RD_SEM, RD_KEY, RD_EN, RD_ST} rdKind_e;

  typedef struct packed {
    logic              semOp;
    logic              semWr;
    logic              lockRd;
    logic [IDX_W-1:0]  idx;
    logic [CORE_W-1:0] core;
    logic [DATA_W-1:0] wdata;
    logic              bulkWr;
    logic              keyWr;
    logic              enWr;
    logic              clrWr;
    logic [CORE_W-1:0] regCore;
    rdKind_e           rdKind;
    logic              rdEn;
  } semStrobe_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic [NUM_PORTS-1:0]             busValid,
  input  logic [NUM_PORTS-1:0]             busWrite,
  input  logic [NUM_PORTS-1:0][CORE_W-1:0] busCore,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] busAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] busWdata,
  output semStrobe_t [NUM_PORTS-1:0]       strobe
);
  localparam logic [ADDR_W-1:0] SEM_END = LR_BASE + ADDR_W'(NUM_SEM);
  localparam logic [ADDR_W-1:0] IRQ_END = IRQ_BASE + ADDR_W'(4 * NUM_CORES);

  function automatic semStrobe_t decode(input logic v, input logic w,
                                        input logic [CORE_W-1:0] c,
                                        input logic [ADDR_W-1:0] a,
                                        input logic [DATA_W-1:0] d);
    semStrobe_t s;
    logic [ADDR_W-1:0] off;
    s = '0;
    s.core  = c;
    s.wdata = d;
    s.rdEn  = v && !w;
    off = a - IRQ_BASE;
    if (v) begin
      if (a < LR_BASE) begin
        s.semOp  = 1'b1;
        s.semWr  = w;
        s.idx    = a[IDX_W-1:0];
        s.rdKind = RD_SEM;
      end else if (a < SEM_END) begin
        s.idx    = a[IDX_W-1:0];
        s.semOp  = !w;
        s.lockRd = !w;
        s.rdKind = RD_SEM;
      end else if (a == CLR_ADDR) begin
        s.bulkWr = w;
      end else if (a == KEY_ADDR) begin
        s.keyWr  = w;
        s.rdKind = RD_KEY;
      end else if (a >= IRQ_BASE && a < IRQ_END) begin
        s.regCore = off[2 +: CORE_W];
        case (off[1:0])
          2'd0: begin s.enWr = w; s.rdKind = RD_EN; end
          2'd1: s.rdKind = RD_ST;
          2'd2: s.clrWr = w;
          default: ;
        endcase
      end
    end
    return s;
  endfunction

  function automatic logic clash(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1);
    return (a0 == a1) ||
           (a0 < SEM_END && a1 < SEM_END && a0[IDX_W-1:0] == a1[IDX_W-1:0]);
  endfunction

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobe[p] = decode(busValid[p], busWrite[p], busCore[p], busAddr[p], busWdata[p]);
      for (int q = 0; q < p; q++) begin
        if (busValid[q] && busValid[p] && clash(busAddr[q], busAddr[p])) begin
          strobe[p].semOp  = 1'b0;
          strobe[p].semWr  = 1'b0;
          strobe[p].lockRd = 1'b0;
          strobe[p].bulkWr = 1'b0;
          strobe[p].keyWr  = 1'b0;
          strobe[p].enWr   = 1'b0;
          strobe[p].clrWr  = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  semStrobe_t [NUM_PORTS-1:0]       strobe,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] busRdata,
  output logic [NUM_CORES-1:0]             irqOut,
  output logic [NUM_SEM-1:0]               semLock,
  output logic [NUM_SEM-1:0][CORE_W-1:0]   semCore,
  output logic [NUM_SEM-1:0][PROC_W-1:0]   semProc,
  output logic [NUM_CORES-1:0][NUM_SEM-1:0] irqStat
);
  logic [NUM_SEM-1:0]                lockQ, lockD, rel;
  logic [NUM_SEM-1:0][CORE_W-1:0]    coreQ, coreD;
  logic [NUM_SEM-1:0][PROC_W-1:0]    procQ, procD;
  logic [KEY_W-1:0]                  keyQ, keyD;
  logic [NUM_CORES-1:0][NUM_SEM-1:0] enQ, enD, stQ, stD, clrMask;
  logic                              bulkOk;
  logic [CORE_W-1:0]                 bulkCore;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  rdD;

  function automatic logic [DATA_W-1:0] packSem(input logic l, input logic [CORE_W-1:0] c,
                                                input logic [PROC_W-1:0] pr);
    logic [DATA_W-1:0] r;
    r = '0;
    r[LOCK_BIT] = l;
    r[CORE_LSB +: CORE_W] = c;
    r[PROC_W-1:0] = pr;
    return r;
  endfunction

  always_comb begin
    lockD = lockQ; coreD = coreQ; procD = procQ;
    keyD = keyQ; enD = enQ; rel = '0; clrMask = '0;
    bulkOk = 1'b0; bulkCore = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobe[p].bulkWr && strobe[p].wdata[DATA_W-1 -: KEY_W] == keyQ) begin
        bulkOk   = 1'b1;
        bulkCore = strobe[p].wdata[CORE_LSB +: CORE_W];
      end
      if (strobe[p].keyWr) keyD = strobe[p].wdata[KEY_W-1:0];
      if (strobe[p].enWr)  enD[strobe[p].regCore] = strobe[p].wdata[NUM_SEM-1:0];
      if (strobe[p].clrWr) clrMask[strobe[p].regCore] = clrMask[strobe[p].regCore] |
                                                         strobe[p].wdata[NUM_SEM-1:0];
    end
    for (int x = 0; x < NUM_SEM; x++)
      if (lockQ[x] && bulkOk && coreQ[x] == bulkCore) rel[x] = 1'b1;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobe[p].semOp) begin
        if ((strobe[p].lockRd || (strobe[p].semWr && strobe[p].wdata[LOCK_BIT])) &&
            !lockQ[strobe[p].idx]) begin
          lockD[strobe[p].idx] = 1'b1;
          coreD[strobe[p].idx] = strobe[p].core;
          procD[strobe[p].idx] = strobe[p].lockRd ? '0 : strobe[p].wdata[PROC_W-1:0];
        end
        if (strobe[p].semWr && !strobe[p].wdata[LOCK_BIT] && lockQ[strobe[p].idx] &&
            coreQ[strobe[p].idx] == strobe[p].core &&
            procQ[strobe[p].idx] == strobe[p].wdata[PROC_W-1:0])
          rel[strobe[p].idx] = 1'b1;
      end
    end
    for (int x = 0; x < NUM_SEM; x++) begin
      if (rel[x]) begin
        lockD[x] = 1'b0;
        coreD[x] = '0;
        procD[x] = '0;
      end
    end
    for (int c = 0; c < NUM_CORES; c++)
      stD[c] = (stQ[c] & ~clrMask[c]) | (rel & enQ[c]);
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      case (strobe[p].rdKind)
        RD_SEM:  rdD[p] = packSem(lockD[strobe[p].idx], coreD[strobe[p].idx],
                                  procD[strobe[p].idx]);
        RD_KEY:  rdD[p] = DATA_W'(keyD);
        RD_EN:   rdD[p] = DATA_W'(enD[strobe[p].regCore]);
        RD_ST:   rdD[p] = DATA_W'(stD[strobe[p].regCore]);
        default: rdD[p] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= '0; coreQ <= '0; procQ <= '0;
      keyQ <= '0; enQ <= '0; stQ <= '0;
    end else begin
      lockQ <= lockD; coreQ <= coreD; procQ <= procD;
      keyQ <= keyD; enQ <= enD; stQ <= stD;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
      always_ff @(posedge clk) begin
        if (!rstN)                busRdata[p] <= '0;
        else if (strobe[p].rdEn)  busRdata[p] <= rdD[p];
      end
    end
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
      assign irqOut[c] = |(stQ[c] & enQ[c]);
    end
  endgenerate

  assign semLock = lockQ;
  assign semCore = coreQ;
  assign semProc = procQ;
  assign irqStat = stQ;
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
  import sem_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PORTS-1:0]             busValid,
  input  logic [NUM_PORTS-1:0]             busWrite,
  input  logic [NUM_PORTS-1:0][CORE_W-1:0] busCore,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] busAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] busWdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] busRdata,
  output logic [NUM_CORES-1:0]             irqOut
);
  semStrobe_t [NUM_PORTS-1:0]        strobe;
  logic [NUM_SEM-1:0]                semLock;
  logic [NUM_SEM-1:0][CORE_W-1:0]    semCore;
  logic [NUM_SEM-1:0][PROC_W-1:0]    semProc;
  logic [NUM_CORES-1:0][NUM_SEM-1:0] irqStat;

  sem_ctrl i_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busCore(busCore),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe)
  );

  sem_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busRdata(busRdata), .irqOut(irqOut),
    .semLock(semLock), .semCore(semCore), .semProc(semProc), .irqStat(irqStat)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
  import sem_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_PORTS-1:0]             busValid,
  input logic [NUM_PORTS-1:0]             busWrite,
  input logic [NUM_PORTS-1:0][CORE_W-1:0] busCore,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] busAddr,
  input logic [NUM_SEM-1:0]               semLock,
  input logic [NUM_SEM-1:0][CORE_W-1:0]   semCore,
  input logic [NUM_SEM-1:0][PROC_W-1:0]   semProc,
  input logic [NUM_CORES-1:0][NUM_SEM-1:0] irqStat
);
  // R1: reset empties every semaphore and every status bit
  a_r1_reset_clean: assert property (@(posedge clk)
    !rstN |=> (semLock == '0 && irqStat == '0));

  generate
    for (genvar x = 0; x < NUM_SEM; x++) begin : g_sem
      logic lrHit0;
      assign lrHit0 = busValid[0] && !busWrite[0] && busAddr[0] == LR_BASE + ADDR_W'(x);

      // R4: a held semaphore keeps its owner until it is released
      a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rstN)
        semLock[x] |=> (!semLock[x] || ($stable(semCore[x]) && $stable(semProc[x]))));

      // R3: a one-step take by port 0 records its core and process 0
      a_r3_lockread_owner: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(semLock[x]) && $past(lrHit0)) |->
          (semProc[x] == '0 && semCore[x] == $past(busCore[0])));

      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // R7: a status bit only rises together with a release
        a_r7_status_on_release: assert property (@(posedge clk) disable iff (!rstN)
          $rose(irqStat[c][x]) |-> $fell(semLock[x]));
      end
    end
  endgenerate
endmodule

bind hw_sem_bank sem_bank_chk i_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busCore(busCore),
  .busAddr(busAddr), .semLock(semLock), .semCore(semCore), .semProc(semProc),
  .irqStat(irqStat)
);

// File: tb/test_hw_sem_bank.sv
`timescale 1ns/1ps
module test_hw_sem_bank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busValid = '0;
  logic [1:0] busWrite = '0;
  logic [1:0][0:0] busCore = '0;
  logic [1:0][7:0] busAddr = '0;
  logic [1:0][31:0] busWdata = '0;
  logic [1:0][31:0] busRdata;
  logic [1:0] irqOut;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  bit mLock[32];
  bit mCore[32];
  logic [7:0] mProc[32];
  logic [15:0] mKey;
  logic [31:0] mEn[2];
  logic [31:0] mSt[2];
  logic [31:0] expRd[2];
  bit needRd[2];

  always #2 clk = ~clk;

  hw_sem_bank i_hw_sem_bank (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busCore(busCore),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] view(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a < 8'h40) begin
      r[31] = mLock[a[4:0]];
      r[8] = mCore[a[4:0]];
      r[7:0] = mProc[a[4:0]];
    end else if (a == 8'h41) r = {16'h0, mKey};
    else if (a >= 8'h50 && a < 8'h58) begin
      if (a[1:0] == 2'd0) r = mEn[a[2]];
      else if (a[1:0] == 2'd1) r = mSt[a[2]];
    end
    return r;
  endfunction

  task automatic modelStep();
    bit nLock[32]; bit nCore[32]; logic [7:0] nProc[32];
    logic [15:0] nKey; logic [31:0] nEn[2]; logic [31:0] clrM[2];
    logic [31:0] rel = '0;
    bit eff[2];
    nLock = mLock; nCore = mCore; nProc = mProc; nKey = mKey; nEn = mEn;
    clrM[0] = '0; clrM[1] = '0;
    eff[0] = busValid[0];
    eff[1] = busValid[1] && !(busValid[0] && (busAddr[0] == busAddr[1] ||
             (busAddr[0] < 8'h40 && busAddr[1] < 8'h40 && busAddr[0][4:0] == busAddr[1][4:0])));
    for (int p = 0; p < 2; p++) begin
      logic [7:0] a = busAddr[p];
      logic [31:0] d = busWdata[p];
      bit w = busWrite[p];
      bit c = busCore[p][0];
      if (!eff[p]) continue;
      if (a < 8'h40) begin
        int x = a[4:0];
        if (a < 8'h20 && w) begin
          if (d[31] && !mLock[x]) begin nLock[x] = 1; nCore[x] = c; nProc[x] = d[7:0]; end
          if (!d[31] && mLock[x] && mCore[x] == c && mProc[x] == d[7:0]) rel[x] = 1;
        end
        if (a >= 8'h20 && !w && !mLock[x]) begin nLock[x] = 1; nCore[x] = c; nProc[x] = 0; end
      end else if (a == 8'h40 && w) begin
        if (d[31:16] == mKey)
          for (int x = 0; x < 32; x++) if (mLock[x] && mCore[x] == d[8]) rel[x] = 1;
      end else if (a == 8'h41 && w) nKey = d[15:0];
      else if (a >= 8'h50 && a < 8'h58 && w) begin
        if (a[1:0] == 2'd0) nEn[a[2]] = d;
        if (a[1:0] == 2'd2) clrM[a[2]] |= d;
      end
    end
    for (int x = 0; x < 32; x++)
      if (rel[x]) begin nLock[x] = 0; nCore[x] = 0; nProc[x] = 0; end
    for (int c = 0; c < 2; c++) mSt[c] = (mSt[c] & ~clrM[c]) | (rel & mEn[c]);
    mLock = nLock; mCore = nCore; mProc = nProc; mKey = nKey; mEn = nEn;
    for (int p = 0; p < 2; p++) begin
      needRd[p] = busValid[p] && !busWrite[p];
      expRd[p] = view(busAddr[p]);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input bit w, input bit c, input logic [7:0] a,
                       input logic [31:0] d);
    busValid[p] = 1'b1; busWrite[p] = w; busCore[p] = c; busAddr[p] = a; busWdata[p] = d;
  endtask

  task automatic tick(input string tag);
    modelStep();
    @(negedge clk);
    for (int p = 0; p < 2; p++)
      if (needRd[p]) check($sformatf("%s port%0d rdata", tag, p), busRdata[p], expRd[p]);
    check($sformatf("%s irqOut (R7)", tag), {30'h0, irqOut},
          {30'h0, |(mSt[1] & mEn[1]), |(mSt[0] & mEn[0])});
    busValid = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int x = 0; x < 32; x++) begin mLock[x] = 0; mCore[x] = 0; mProc[x] = 0; end
    mKey = 0; mEn[0] = 0; mEn[1] = 0; mSt[0] = 0; mSt[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state seen through reads
    drive(0, 0, 0, 8'h05, 0); drive(1, 0, 1, 8'h41, 0); tick("R1 sem/key");
    drive(0, 0, 0, 8'h50, 0); drive(1, 0, 1, 8'h55, 0); tick("R1 en/status");
    // R2: two-step lock; core field in data ignored
    drive(0, 1, 0, 8'h03, 32'h8000_012A); tick("R2 lock write");
    drive(0, 0, 0, 8'h03, 0); tick("R2 readback");
    check("R2 literal owner", busRdata[0], 32'h8000_002A);
    // R4: other core cannot take a held semaphore
    drive(1, 1, 1, 8'h03, 32'h8000_0005); tick("R4 lock write held");
    drive(1, 0, 1, 8'h23, 0); tick("R4 lockread held");
    check("R4 literal owner", busRdata[1], 32'h8000_002A);
    // R3: one-step lock by core 1
    drive(1, 0, 1, 8'h27, 0); tick("R3 lockread");
    check("R3 literal", busRdata[1], 32'h8000_0100);
    // R9: plain read keeps state
    drive(0, 0, 0, 8'h07, 0); tick("R9 plain read");
    // R11: write to lock-read reg ignored, unmapped read 0
    drive(0, 1, 0, 8'h29, 32'h8000_0001); tick("R11 lockread write");
    drive(0, 0, 0, 8'h09, 0); drive(1, 0, 1, 8'h7F, 0); tick("R11 ignored/unmapped");
    // R5: mismatched unlocks ignored, matching unlock frees
    drive(0, 1, 0, 8'h07, 32'h0); tick("R5 wrong core");
    drive(1, 1, 1, 8'h07, 32'h3); tick("R5 wrong pid");
    drive(1, 0, 1, 8'h07, 0); tick("R5 still held");
    drive(1, 1, 1, 8'h07, 32'h0); tick("R5 good unlock");
    drive(1, 0, 1, 8'h07, 0); tick("R5 freed");
    // R7 / R8: release interrupt and clear
    drive(0, 1, 0, 8'h54, 32'h8); tick("R7 enable");
    drive(0, 1, 0, 8'h03, 32'h0000_002A); tick("R7 release");
    check("R7 literal irq", {30'h0, irqOut}, 32'h2);
    drive(1, 0, 1, 8'h55, 0); tick("R7 status read");
    drive(1, 1, 1, 8'h56, 32'h8); tick("R8 clear");
    check("R8 literal irq", {30'h0, irqOut}, 32'h0);
    drive(0, 1, 0, 8'h03, 32'h8000_0001); tick("R8 relock");
    drive(0, 1, 0, 8'h03, 32'h0000_0001); drive(1, 1, 1, 8'h56, 32'h8); tick("R8 release beats clear");
    drive(1, 1, 1, 8'h56, 32'h8); tick("R8 clear again");
    // R6: bulk release with key
    drive(0, 1, 1, 8'h01, 32'h8000_0004); drive(1, 1, 1, 8'h02, 32'h8000_0004); tick("R6 lock 1,2");
    drive(0, 1, 0, 8'h04, 32'h8000_0009); drive(1, 1, 1, 8'h41, 32'h0000_BEEF); tick("R6 lock 4, key");
    drive(0, 0, 0, 8'h41, 0); tick("R6 key read");
    drive(0, 1, 0, 8'h40, 32'hBEEE_0100); tick("R6 wrong key");
    drive(0, 0, 0, 8'h01, 0); tick("R6 still held");
    drive(0, 1, 0, 8'h40, 32'hBEEF_0100); tick("R6 good key");
    drive(0, 0, 0, 8'h02, 0); drive(1, 0, 1, 8'h04, 0); tick("R6 after bulk");
    check("R6 literal core0 kept", busRdata[1], 32'h8000_0009);
    // R10: both ports race for one free semaphore
    drive(0, 0, 0, 8'h2B, 0); drive(1, 0, 1, 8'h2B, 0); tick("R10 race");
    check("R10 literal port1", busRdata[1], 32'h8000_0000);
    drive(0, 1, 0, 8'h41, 32'h1); drive(1, 1, 1, 8'h41, 32'h2); tick("R10 same addr");
    drive(0, 0, 0, 8'h41, 0); tick("R10 key from port0");
    // random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        int k = $urandom_range(0, 9);
        logic [7:0] a;
        logic [31:0] d;
        bit w = $urandom_range(0, 1);
        case (k)
          0, 1, 2: a = 8'(($urandom_range(0, 3)));
          3, 4:    a = 8'h20 + 8'(($urandom_range(0, 3)));
          5:       a = 8'h40;
          6:       a = 8'h41;
          7, 8:    a = 8'h50 + 8'(($urandom_range(0, 6)));
          default: a = 8'h7F;
        endcase
        d = {$urandom_range(0, 1) ? 16'h1234 : mKey, 7'h0, 1'(($urandom_range(0, 1))),
             8'(($urandom_range(0, 2)))};
        if (a == 8'h41) d = $urandom_range(0, 1) ? 32'h1234 : 32'h0;
        else if (a >= 8'h50) d = 32'(($urandom_range(0, 15)));
        else if (a < 8'h40) d[31] = $urandom_range(0, 1);
        if ($urandom_range(0, 4) != 0) drive(p, w, 1'(($urandom_range(0, 1))), a, d);
      end
      tick("R10/R11 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule